// File: doc/BRIEF.md
# VIPT L1 Data Cache Lookup

This block is the lookup path of a level-one data cache. It reads the tag and data arrays using only address bits that translation leaves unchanged, while a translation buffer outside the block works out the physical page number in the same cycle. The physical page number then goes to every way's stored tag. Tags hold physical page numbers, so two virtual pages that map to one physical page both find the same line.

The default geometry is a 24-bit virtual address, 4 KB pages, 64-byte lines, 64 sets and 16 ways, which gives 64 KB. The set index and line offset together fill the 12 page-offset bits exactly. Because of this, no virtual page bit ever selects a set, and no alias copies can form.

A request that arrives without a valid translation is held back. A request with a valid translation gets its hit flag, way and read word one cycle later. On a miss, the reported way is the tree pseudo-LRU victim of the set, and the refill port writes a whole line into the chosen set and way.

Top module: `vipt_l1_lookup`

## Requirements
- R1: After reset no line is valid, so every lookup misses; with no request, `req_stall`, `rsp_valid` and `rsp_hit` are 0.
- R2: A request accepted with `req_valid`=1 and `tlb_hit`=1 gives `rsp_valid`=1 in the next cycle. `rsp_valid` is 0 in any cycle that does not follow an accepted request.
- R3: When `req_valid`=1 and `tlb_hit`=0, `req_stall` is 1 in that same cycle and no response follows, even if `tlb_ppn` matches a stored tag. The requester keeps `req_va` unchanged while it is stalled.
- R4: `rsp_hit`=1 exactly when some way holds a valid line in set `req_va[11:6]` whose physical tag equals `tlb_ppn`. `rsp_way` then gives that way's number.
- R5: On a hit, `rsp_data` is the 32-bit word `req_va[5:2]` of the line. Word k occupies bits [32k+31:32k] of `fill_line`.
- R6: Virtual page bits `req_va[23:12]` play no part in the outcome, so two virtual pages with the same offset and the same translation hit the same way.
- R7: A valid line in the set whose tag differs from `tlb_ppn` does not hit, even when that page number is held in another set.
- R8: On a miss, `rsp_way` is the set's tree pseudo-LRU victim. Starting from reset, the k-th fill into the reported victim of one set lands in the way whose 4-bit number is k with its bits reversed (0, 8, 4, 12, 2, ...).
- R9: A hit refreshes that way in the set's pseudo-LRU state. After the 16 fills of R8, a hit on way 0 moves the victim to way 8.
- R10: A fill with `fill_valid`=1 writes the tag, the line and the valid bit at (`fill_set`, `fill_way`) at the clock edge. A lookup in the same cycle still sees the previous contents.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Lookup request |
| req_va | input | 24 | Virtual byte address |
| tlb_hit | input | 1 | Translation valid for this request |
| tlb_ppn | input | 12 | Translated physical page number |
| req_stall | output | 1 | Request waits for translation |
| rsp_valid | output | 1 | Response present |
| rsp_hit | output | 1 | Line found |
| rsp_way | output | 4 | Hit way, or victim way on a miss |
| rsp_data | output | 32 | Word read on a hit |
| fill_valid | input | 1 | Refill write |
| fill_set | input | 6 | Refill set |
| fill_way | input | 4 | Refill way |
| fill_ppn | input | 12 | Physical tag of the refilled line |
| fill_line | input | 512 | Refill line data |

## Verification
`req_stall` depends only on the inputs of the current cycle, so it is sampled in the cycle the request is driven. `rsp_valid`, `rsp_hit`, `rsp_way` and `rsp_data` pass through a single register, so they are read one cycle after the request. A fill takes effect at the edge that ends its cycle, so a lookup in the same cycle is expected to return the old line and the following lookup the new one.

The bench drives every input at the falling edge and reads every output at the next falling edge. It fills all 1024 lines with tags and data that it can compute, then reads each line back through a different virtual page.

// File: rtl/vipt_pkg.sv
package vipt_pkg;
  localparam int unsigned VA_BITS   = 24;
  localparam int unsigned PAGE_BITS = 12;
  localparam int unsigned LINE_BITS = 6;
  localparam int unsigned NUM_WAYS  = 16;
  localparam int unsigned PPN_BITS  = 12;
  localparam int unsigned WORD_BITS = 32;
endpackage

// File: rtl/vipt_way.sv
module vipt_way #(
  parameter int unsigned SET_W   = 6,
  parameter int unsigned PPN_W   = 12,
  parameter int unsigned LINE_DW = 512
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [SET_W-1:0]   lk_set,
  input  logic [PPN_W-1:0]   lk_ppn,
  input  logic               fill_en,
  input  logic [SET_W-1:0]   fill_set,
  input  logic [PPN_W-1:0]   fill_ppn,
  input  logic [LINE_DW-1:0] fill_line,
  output logic               hit,
  output logic [LINE_DW-1:0] line_out
);
  localparam int unsigned SETS = 1 << SET_W;

  logic [SETS-1:0]    valid_q, valid_d;
  logic [PPN_W-1:0]   tag_q  [SETS];
  logic [LINE_DW-1:0] data_q [SETS];

  always_comb begin
    valid_d = valid_q;
    if (fill_en) valid_d[fill_set] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) valid_q <= '0;
    else        valid_q <= valid_d;
  end

  // tag and data arrays carry no reset; the valid bits guard them
  always_ff @(posedge clk) begin
    if (fill_en) begin
      tag_q[fill_set]  <= fill_ppn;
      data_q[fill_set] <= fill_line;
    end
  end

  assign hit      = valid_q[lk_set] && (tag_q[lk_set] == lk_ppn);
  assign line_out = data_q[lk_set];

  // R10
  fill_sets_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fill_en |=> valid_q[$past(fill_set)]);
endmodule

// File: rtl/vipt_plru.sv
module vipt_plru #(
  parameter int unsigned WAYS  = 16,
  parameter int unsigned SET_W = 6
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [SET_W-1:0]        lk_set,
  output logic [$clog2(WAYS)-1:0] victim,
  input  logic                    hit_en,
  input  logic [SET_W-1:0]        hit_set,
  input  logic [$clog2(WAYS)-1:0] hit_way,
  input  logic                    fill_en,
  input  logic [SET_W-1:0]        fill_set,
  input  logic [$clog2(WAYS)-1:0] fill_way
);
  localparam int unsigned LVL   = $clog2(WAYS);
  localparam int unsigned NODES = WAYS - 1;
  localparam int unsigned SETS  = 1 << SET_W;

  logic [NODES-1:0] tree_q [SETS];
  logic [NODES-1:0] tree_d [SETS];

  // node bit 0: victim lies in the lower half below that node
  function automatic logic [NODES-1:0] touch(input logic [NODES-1:0] b,
                                             input logic [LVL-1:0]   w);
    logic [NODES-1:0] r;
    int n;
    r = b;
    n = 0;
    for (int l = 0; l < LVL; l++) begin
      r[n] = ~w[LVL-1-l];
      n    = 2 * n + 1 + int'(w[LVL-1-l]);
    end
    return r;
  endfunction

  function automatic logic [LVL-1:0] pick(input logic [NODES-1:0] b);
    logic [LVL-1:0] v;
    int n;
    v = '0;
    n = 0;
    for (int l = 0; l < LVL; l++) begin
      v[LVL-1-l] = b[n];
      n          = 2 * n + 1 + int'(b[n]);
    end
    return v;
  endfunction

  assign victim = pick(tree_q[lk_set]);

  always_comb begin
    for (int s = 0; s < SETS; s++) tree_d[s] = tree_q[s];
    if (hit_en)  tree_d[hit_set]  = touch(tree_q[hit_set], hit_way);
    if (fill_en) tree_d[fill_set] = touch(tree_q[fill_set], fill_way);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < SETS; s++) tree_q[s] <= '0;
    end else begin
      for (int s = 0; s < SETS; s++) tree_q[s] <= tree_d[s];
    end
  end

  // R8
  recent_not_victim_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fill_en |=> (pick(tree_q[$past(fill_set)]) != $past(fill_way)));
endmodule

// File: rtl/vipt_l1_lookup.sv
module vipt_l1_lookup
  import vipt_pkg::*;
#(
  parameter int unsigned VA_W   = VA_BITS,
  parameter int unsigned PAGE_W = PAGE_BITS,
  parameter int unsigned LINE_W = LINE_BITS,
  parameter int unsigned WAYS   = NUM_WAYS,
  parameter int unsigned PPN_W  = PPN_BITS,
  parameter int unsigned WORD_W = WORD_BITS,
  localparam int unsigned SET_W   = PAGE_W - LINE_W,
  localparam int unsigned WAY_W   = $clog2(WAYS),
  localparam int unsigned LINE_DW = 8 << LINE_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  input  logic [VA_W-1:0]    req_va,
  input  logic               tlb_hit,
  input  logic [PPN_W-1:0]   tlb_ppn,
  output logic               req_stall,
  output logic               rsp_valid,
  output logic               rsp_hit,
  output logic [WAY_W-1:0]   rsp_way,
  output logic [WORD_W-1:0]  rsp_data,
  input  logic               fill_valid,
  input  logic [SET_W-1:0]   fill_set,
  input  logic [WAY_W-1:0]   fill_way,
  input  logic [PPN_W-1:0]   fill_ppn,
  input  logic [LINE_DW-1:0] fill_line
);
  localparam int unsigned BSEL_W = $clog2(WORD_W / 8);
  localparam int unsigned WSEL_W = LINE_W - BSEL_W;

  // reset: asserted at once, released through two flops
  logic rst_meta, rst_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_q    <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_q    <= rst_meta;
    end
  end

  // index and word select come only from page-offset bits
  logic [SET_W-1:0]  lk_set;
  logic [WSEL_W-1:0] lk_word;
  logic              accept;
  assign lk_set    = req_va[PAGE_W-1:LINE_W];
  assign lk_word   = req_va[LINE_W-1:BSEL_W];
  assign accept    = req_valid && tlb_hit;
  assign req_stall = req_valid && !tlb_hit;

  logic [WAYS-1:0]    hit_vec;
  logic [LINE_DW-1:0] line_arr [WAYS];

  for (genvar g = 0; g < WAYS; g++) begin : g_way
    vipt_way #(.SET_W(SET_W), .PPN_W(PPN_W), .LINE_DW(LINE_DW)) u_way (
      .clk      (clk),
      .rst_n    (rst_q),
      .lk_set   (lk_set),
      .lk_ppn   (tlb_ppn),
      .fill_en  (fill_valid && (fill_way == WAY_W'(g))),
      .fill_set (fill_set),
      .fill_ppn (fill_ppn),
      .fill_line(fill_line),
      .hit      (hit_vec[g]),
      .line_out (line_arr[g])
    );
  end

  logic               hit_any;
  logic [WAY_W-1:0]   hit_idx;
  logic [LINE_DW-1:0] sel_line;
  logic [WORD_W-1:0]  sel_word;
  logic [WAY_W-1:0]   victim;

  always_comb begin
    hit_idx  = '0;
    sel_line = '0;
    for (int w = 0; w < WAYS; w++) begin
      if (hit_vec[w]) hit_idx = hit_idx | WAY_W'(w);
      sel_line = sel_line | ({LINE_DW{hit_vec[w]}} & line_arr[w]);
    end
  end
  assign hit_any  = |hit_vec;
  assign sel_word = sel_line[lk_word*WORD_W +: WORD_W];

  vipt_plru #(.WAYS(WAYS), .SET_W(SET_W)) u_plru (
    .clk     (clk),
    .rst_n   (rst_q),
    .lk_set  (lk_set),
    .victim  (victim),
    .hit_en  (accept && hit_any),
    .hit_set (lk_set),
    .hit_way (hit_idx),
    .fill_en (fill_valid),
    .fill_set(fill_set),
    .fill_way(fill_way)
  );

  // response stage: next state, then registers
  logic              valid_d, hit_d;
  logic [WAY_W-1:0]  way_d;
  logic [WORD_W-1:0] data_d;
  always_comb begin
    valid_d = accept;
    hit_d   = accept && hit_any;
    way_d   = hit_any ? hit_idx : victim;
    data_d  = hit_any ? sel_word : '0;
  end

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) begin
      rsp_valid <= 1'b0;
      rsp_hit   <= 1'b0;
    end else begin
      rsp_valid <= valid_d;
      rsp_hit   <= hit_d;
    end
  end

  always_ff @(posedge clk) begin
    if (accept) begin
      rsp_way  <= way_d;
      rsp_data <= data_d;
    end
  end

  // R4
  way_unique_chk: assert property (@(posedge clk) disable iff (!rst_q)
    $onehot0(hit_vec));
  // R2
  hit_has_valid_chk: assert property (@(posedge clk) disable iff (!rst_q)
    rsp_hit |-> rsp_valid);
  // R2
  rsp_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_q)
    rsp_valid |-> ($past(req_valid) && $past(tlb_hit)));
  // R3
  stall_no_rsp_chk: assert property (@(posedge clk) disable iff (!rst_q)
    req_stall |=> !rsp_valid);
  // R3
  stall_holds_addr_chk: assert property (@(posedge clk) disable iff (!rst_q)
    req_stall |=> (!req_valid || $stable(req_va)));
endmodule

// File: tb/test_vipt_l1_lookup.sv
`timescale 1ns/1ps
module test_vipt_l1_lookup;
  logic         clk = 1'b0;
  logic         rst_n;
  logic         req_valid, tlb_hit, fill_valid;
  logic [23:0]  req_va;
  logic [11:0]  tlb_ppn, fill_ppn;
  logic [5:0]   fill_set;
  logic [3:0]   fill_way;
  logic [511:0] fill_line;
  logic         req_stall, rsp_valid, rsp_hit;
  logic [3:0]   rsp_way;
  logic [31:0]  rsp_data;

  int n_chk  = 0;
  int n_fail = 0;

  always #4 clk = ~clk;

  vipt_l1_lookup i_vipt_l1_lookup (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_va(req_va),
    .tlb_hit(tlb_hit), .tlb_ppn(tlb_ppn), .req_stall(req_stall),
    .rsp_valid(rsp_valid), .rsp_hit(rsp_hit), .rsp_way(rsp_way),
    .rsp_data(rsp_data), .fill_valid(fill_valid), .fill_set(fill_set),
    .fill_way(fill_way), .fill_ppn(fill_ppn), .fill_line(fill_line)
  );

  function automatic logic [31:0] word_of(input logic [11:0] ppn, input logic [5:0] s,
                                          input logic [3:0] w, input logic [3:0] k);
    return {ppn, 2'b00, s, 4'h0, w, k};
  endfunction

  function automatic logic [511:0] line_of(input logic [11:0] ppn, input logic [5:0] s,
                                           input logic [3:0] w);
    logic [511:0] l;
    for (int k = 0; k < 16; k++) l[32*k +: 32] = word_of(ppn, s, w, 4'(k));
    return l;
  endfunction

  function automatic logic [3:0] brev(input logic [3:0] x);
    return {x[0], x[1], x[2], x[3]};
  endfunction

  function automatic logic [11:0] ppn_of(input int s, input int w);
    return 12'(12'h400 + s * 16 + w);
  endfunction

  task automatic chk(input bit ok, input string req, input logic [63:0] act,
                     input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic drive_req(input logic [11:0] vpn, input logic [5:0] s,
                           input logic [3:0] k, input logic [11:0] ppn);
    req_valid = 1'b1;
    req_va    = {vpn, s, k, 2'b10};
    tlb_hit   = 1'b1;
    tlb_ppn   = ppn;
  endtask

  task automatic drive_fill(input logic [5:0] s, input logic [3:0] w, input logic [11:0] ppn);
    fill_valid = 1'b1;
    fill_set   = s;
    fill_way   = w;
    fill_ppn   = ppn;
    fill_line  = line_of(ppn, s, w);
  endtask

  task automatic idle_inputs();
    req_valid  = 1'b0;
    tlb_hit    = 1'b0;
    fill_valid = 1'b0;
  endtask

  task automatic lookup(input logic [11:0] vpn, input logic [5:0] s,
                        input logic [3:0] k, input logic [11:0] ppn);
    @(negedge clk);
    drive_req(vpn, s, k, ppn);
    @(negedge clk);
    idle_inputs();
  endtask

  task automatic fill(input logic [5:0] s, input logic [3:0] w, input logic [11:0] ppn);
    @(negedge clk);
    drive_fill(s, w, ppn);
    @(negedge clk);
    idle_inputs();
  endtask

  task automatic expect_hit(input string req, input logic [3:0] w, input logic [31:0] d);
    chk(rsp_valid === 1'b1, req, 64'(rsp_valid), 64'd1);
    chk(rsp_hit === 1'b1, req, 64'(rsp_hit), 64'd1);
    chk(rsp_way === w, req, 64'(rsp_way), 64'(w));
    chk(rsp_data === d, req, 64'(rsp_data), 64'(d));
  endtask

  task automatic expect_miss(input string req);
    chk(rsp_valid === 1'b1, req, 64'(rsp_valid), 64'd1);
    chk(rsp_hit === 1'b0, req, 64'(rsp_hit), 64'd0);
  endtask

  task automatic summary();
    $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog actual=hung expected=done");
    summary();
    $finish;
  end

  initial begin
    idle_inputs();
    req_va = '0; tlb_ppn = '0; fill_set = '0; fill_way = '0; fill_ppn = '0; fill_line = '0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state and empty cache
    chk(req_stall === 1'b0, "R1 stall", 64'(req_stall), 64'd0);
    chk(rsp_valid === 1'b0, "R1 valid", 64'(rsp_valid), 64'd0);
    chk(rsp_hit === 1'b0, "R1 hit", 64'(rsp_hit), 64'd0);
    lookup(12'h123, 6'd0, 4'd0, 12'h000);
    expect_miss("R1 empty lookup");
    @(negedge clk);
    chk(rsp_valid === 1'b0, "R2 no request", 64'(rsp_valid), 64'd0);

    // R8 victim order on a fresh set
    for (int k = 0; k < 16; k++) begin
      lookup(12'(k * 3), 6'd5, 4'd1, 12'(12'h800 + k));
      expect_miss("R8 miss");
      chk(rsp_way === brev(4'(k)), "R8 victim", 64'(rsp_way), 64'(brev(4'(k))));
      fill(6'd5, rsp_way, 12'(12'h800 + k));
    end
    // R9 hit refreshes way 0
    lookup(12'h0AA, 6'd5, 4'd2, 12'h800);
    expect_hit("R9 hit way0", 4'd0, word_of(12'h800, 6'd5, 4'd0, 4'd2));
    lookup(12'h0AB, 6'd5, 4'd0, 12'hFFF);
    expect_miss("R9 miss");
    chk(rsp_way === 4'd8, "R9 victim", 64'(rsp_way), 64'd8);

    // R4 R5 R6 sweep: fill all lines, then read each one back
    for (int s = 0; s < 64; s++)
      for (int w = 0; w < 16; w++)
        fill(6'(s), 4'(w), ppn_of(s, w));
    for (int s = 0; s < 64; s++)
      for (int w = 0; w < 16; w++) begin
        lookup(12'(s * 37 + w * 11 + 5), 6'(s), 4'((s + w) % 16), ppn_of(s, w));
        expect_hit("R4 R5 R6 sweep", 4'(w), word_of(ppn_of(s, w), 6'(s), 4'(w), 4'((s + w) % 16)));
      end

    // R6 synonyms: two virtual pages, one physical page
    lookup(12'h111, 6'd7, 4'd9, ppn_of(7, 12));
    expect_hit("R6 first page", 4'd12, word_of(ppn_of(7, 12), 6'd7, 4'd12, 4'd9));
    lookup(12'hEEE, 6'd7, 4'd9, ppn_of(7, 12));
    expect_hit("R6 second page", 4'd12, word_of(ppn_of(7, 12), 6'd7, 4'd12, 4'd9));

    // R7 tag of another set does not hit
    lookup(12'h222, 6'd9, 4'd0, ppn_of(10, 0));
    expect_miss("R7 foreign tag");

    // R3 stall until translation, matching ppn present
    @(negedge clk);
    req_valid = 1'b1; req_va = {12'h333, 6'd4, 4'd6, 2'b00};
    tlb_hit = 1'b0; tlb_ppn = ppn_of(4, 3);
    #1;
    chk(req_stall === 1'b1, "R3 stall", 64'(req_stall), 64'd1);
    @(negedge clk);
    chk(rsp_valid === 1'b0, "R3 no response", 64'(rsp_valid), 64'd0);
    chk(rsp_hit === 1'b0, "R3 no hit", 64'(rsp_hit), 64'd0);
    tlb_hit = 1'b1;
    #1;
    chk(req_stall === 1'b0, "R3 released", 64'(req_stall), 64'd0);
    @(negedge clk);
    idle_inputs();
    expect_hit("R3 after translation", 4'd3, word_of(ppn_of(4, 3), 6'd4, 4'd3, 4'd6));

    // R10 fill and lookup in the same cycle
    @(negedge clk);
    drive_req(12'h444, 6'd3, 4'd4, ppn_of(3, 2));
    drive_fill(6'd3, 4'd2, 12'h900);
    @(negedge clk);
    idle_inputs();
    expect_hit("R10 old contents", 4'd2, word_of(ppn_of(3, 2), 6'd3, 4'd2, 4'd4));
    lookup(12'h445, 6'd3, 4'd15, 12'h900);
    expect_hit("R10 new line", 4'd2, word_of(12'h900, 6'd3, 4'd2, 4'd15));
    lookup(12'h446, 6'd3, 4'd4, ppn_of(3, 2));
    expect_miss("R10 old tag gone");

    summary();
    $finish;
  end
endmodule